// File: doc/BRIEF.md
# Ping-Pong Video Frame Buffer Switch

This block sits between a 4-bit media-independent receive stream and two external SRAM banks. It uses the banks as a double buffer for a panel controller. The block gathers incoming nibbles into 24-bit RGB pixels and stores each pixel at the next address of the bank that currently holds the write role. The display scanner reads the other bank without any interruption.

A single bank-select flag decides the roles of the two banks. After a full frame of `FRAME_PIX` pixels has been stored, the block holds that frame pending and stops taking further nibbles. When the scanner signals that it is between two frames, the flag flips, so the scanner always moves to the newest complete frame and never shows a torn image. A receive error throws away a partly received frame, and writing starts again at address zero.

Top module: `pp_frame_buf`

## Requirements
- R1: After reset, `frame_sel` is 0, bank 0 has the read role, bank 1 has the write role, and neither bank write strobe is high.
- R2: Six accepted nibbles form one pixel. Nibble k (k = 0..5) lands in byte k/2 of the colour order red, green, blue, and in the low half of that byte when k is even. Red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R3: Each finished pixel is written to the write-role bank (bank 1 when `frame_sel` = 0, bank 0 when it is 1). Addresses run 0, 1, 2 … in order. The two write strobes are never high together.
- R4: The read-role bank always receives `rd_addr` and `rd_en`. `rd_data` always shows that bank's read data, and the read-role bank's write strobe stays low, whatever reception is doing.
- R5: When the `FRAME_PIX`-th pixel of a frame is written, the frame becomes pending. `frame_sel` inverts on the first clock edge at which `rd_frame_start` is high while a frame is pending, and at no other time.
- R6: While a frame is pending, incoming nibbles are ignored and no bank write happens.
- R7: After a role swap, writing starts at address 0 of the newly write-role bank.
- R8: A cycle with `rx_er` high and no frame pending drops the partial pixel and the partial frame. The next pixel goes to address 0, and the dropped frame never causes a swap.
- R9: `rd_frame_start` with no frame pending leaves `frame_sel` unchanged.
- R10: Cycles with `rx_dv` low do not advance the pixel assembly, so the nibbles of a pixel may arrive with idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Receive nibble valid |
| rx_er | input | 1 | Receive error, drops the partial frame |
| rx_nib | input | 4 | Receive nibble |
| rd_frame_start | input | 1 | Scanner is between frames, so a swap is allowed |
| rd_en | input | 1 | Scanner read enable |
| rd_addr | input | AW | Scanner pixel address |
| rd_data | output | 24 | Pixel from the read-role bank |
| frame_sel | output | 1 | Bank-select flag (0: bank 0 read, bank 1 written) |
| b0_addr | output | AW | Bank 0 address |
| b0_wdata | output | 24 | Bank 0 write data |
| b0_we | output | 1 | Bank 0 write strobe |
| b0_re | output | 1 | Bank 0 read enable |
| b0_rdata | input | 24 | Bank 0 read data |
| b1_addr | output | AW | Bank 1 address |
| b1_wdata | output | 24 | Bank 1 write data |
| b1_we | output | 1 | Bank 1 write strobe |
| b1_re | output | 1 | Bank 1 read enable |
| b1_rdata | input | 24 | Bank 1 read data |

## Verification
The hardest case to reach is a receive error that arrives after an earlier frame has already swapped in, with a partial frame half written into the other bank. The bench does this by swapping once, then sending three pixels and two stray nibbles, then pulsing the error. It then offers a frame boundary, which must not swap, and sends a clean frame. Any stale address or stale nibble phase would leave the clean frame misplaced in the bank model, and the bench compares every word against values it computes itself.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int NIB_PER_PIX = 6;
  localparam int PIX_W       = 24;
  typedef logic [PIX_W-1:0] pixel_t;
endpackage

// File: rtl/pp_nib_pack.sv
module pp_nib_pack
  import pp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nib_vld,
  input  logic [3:0] nib,
  input  logic       nib_err,
  input  logic       hold,
  output logic       pix_vld,
  output pixel_t     pix_data
);
  localparam logic [2:0] LAST_PH = 3'(NIB_PER_PIX - 1);

  logic [2:0] phase_q, phase_d;
  pixel_t     acc_q, acc_d, pix_d;
  logic       pv_d;
  logic [1:0] slot;
  logic [4:0] base;
  logic       take;

  // byte slot counts down from red (2) to blue (0); odd nibble takes upper half
  always_comb begin
    slot = 2'd2 - phase_q[2:1];
    base = {slot, phase_q[0], 2'b00};
  end

  always_comb begin
    phase_d = phase_q;
    acc_d   = acc_q;
    pix_d   = pix_data;
    pv_d    = 1'b0;
    take    = nib_vld & ~hold;
    if (nib_err) begin
      phase_d = '0;
    end else if (take) begin
      acc_d[base +: 4] = nib;
      if (phase_q == LAST_PH) begin
        phase_d = '0;
        pv_d    = 1'b1;
        pix_d   = acc_d;
      end else begin
        phase_d = phase_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      acc_q    <= '0;
      pix_vld  <= 1'b0;
      pix_data <= '0;
    end else begin
      phase_q <= phase_d;
      acc_q   <= acc_d;
      pix_vld <= pv_d;
      if (pv_d) pix_data <= pix_d;
    end
  end

  assert_phase_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST_PH) else $error("nibble phase out of range");

  assert_idle_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (!nib_vld && !nib_err) |=> (phase_q == $past(phase_q)))
    else $error("phase moved without valid nibble");
endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl #(
  parameter int FRAME_PIX = 768,
  parameter int AW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_vld,
  input  logic          rx_err,
  input  logic          rd_frame_start,
  output logic [AW-1:0] wr_addr,
  output logic          wr_en,
  output logic          frame_sel,
  output logic          hold
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(FRAME_PIX - 1);

  logic [AW-1:0] addr_d;
  logic          sel_d, pend_q, pend_d;
  logic          last_pix;

  always_comb begin
    last_pix = pix_vld && (wr_addr == LAST_ADDR);
    hold     = pend_q | last_pix;
    wr_en    = pix_vld & ~pend_q & ~rx_err;
  end

  always_comb begin
    addr_d = wr_addr;
    sel_d  = frame_sel;
    pend_d = pend_q;
    if (pend_q) begin
      if (rd_frame_start) begin
        sel_d  = ~frame_sel;
        pend_d = 1'b0;
        addr_d = '0;
      end
    end else if (rx_err) begin
      addr_d = '0;
    end else if (pix_vld) begin
      if (last_pix) begin
        addr_d = '0;
        pend_d = 1'b1;
      end else begin
        addr_d = wr_addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr   <= '0;
      frame_sel <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      wr_addr   <= addr_d;
      frame_sel <= sel_d;
      pend_q    <= pend_d;
    end
  end

  assert_swap_on_boundary_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sel != $past(frame_sel)) |-> $past(pend_q && rd_frame_start))
    else $error("swap without pending frame and boundary");

  assert_addr_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr <= LAST_ADDR) else $error("write address past frame");

  assert_pending_quiet_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !wr_en) else $error("write while frame pending");

  assert_err_restart_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !pend_q) |=> (wr_addr == '0)) else $error("error did not restart");

  assert_swap_restart_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && rd_frame_start) |=> (wr_addr == '0 && !pend_q))
    else $error("swap did not restart write side");
endmodule

// File: rtl/pp_bank_mux.sv
module pp_bank_mux
  import pp_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          frame_sel,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  pixel_t        wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  pixel_t        rdata0,
  input  pixel_t        rdata1,
  output logic [AW-1:0] addr0,
  output logic [AW-1:0] addr1,
  output pixel_t        wdata0,
  output pixel_t        wdata1,
  output logic [1:0]    we,
  output logic [1:0]    re,
  output pixel_t        rd_data
);
  logic [AW-1:0] addr_a [2];
  pixel_t        wdata_a [2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_bank
    logic wr_role;
    always_comb begin
      wr_role     = (frame_sel != 1'(gi));
      addr_a[gi]  = wr_role ? wr_addr : rd_addr;
      wdata_a[gi] = wr_data;
      we[gi]      = wr_role & wr_en;
      re[gi]      = ~wr_role & rd_en;
    end
  end

  always_comb begin
    addr0   = addr_a[0];
    addr1   = addr_a[1];
    wdata0  = wdata_a[0];
    wdata1  = wdata_a[1];
    rd_data = frame_sel ? rdata1 : rdata0;
  end
endmodule

// File: rtl/pp_frame_buf.sv
module pp_frame_buf
  import pp_pkg::*;
#(
  parameter int FRAME_PIX = 768,
  localparam int AW       = (FRAME_PIX > 1) ? $clog2(FRAME_PIX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_dv,
  input  logic          rx_er,
  input  logic [3:0]    rx_nib,
  input  logic          rd_frame_start,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [23:0]   rd_data,
  output logic          frame_sel,
  output logic [AW-1:0] b0_addr,
  output logic [23:0]   b0_wdata,
  output logic          b0_we,
  output logic          b0_re,
  input  logic [23:0]   b0_rdata,
  output logic [AW-1:0] b1_addr,
  output logic [23:0]   b1_wdata,
  output logic          b1_we,
  output logic          b1_re,
  input  logic [23:0]   b1_rdata
);
  logic [1:0]    rst_sync_q;
  logic          rst_q_n;
  logic          pix_vld, hold, wr_en;
  pixel_t        pix_data;
  logic [AW-1:0] wr_addr;
  logic [1:0]    we_v, re_v;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  pp_nib_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .nib_vld  (rx_dv),
    .nib      (rx_nib),
    .nib_err  (rx_er),
    .hold     (hold),
    .pix_vld  (pix_vld),
    .pix_data (pix_data)
  );

  pp_swap_ctrl #(.FRAME_PIX(FRAME_PIX), .AW(AW)) u_swap (
    .clk            (clk),
    .rst_n          (rst_q_n),
    .pix_vld        (pix_vld),
    .rx_err         (rx_er),
    .rd_frame_start (rd_frame_start),
    .wr_addr        (wr_addr),
    .wr_en          (wr_en),
    .frame_sel      (frame_sel),
    .hold           (hold)
  );

  pp_bank_mux #(.AW(AW)) u_mux (
    .frame_sel (frame_sel),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (pix_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rdata0    (b0_rdata),
    .rdata1    (b1_rdata),
    .addr0     (b0_addr),
    .addr1     (b1_addr),
    .wdata0    (b0_wdata),
    .wdata1    (b1_wdata),
    .we        (we_v),
    .re        (re_v),
    .rd_data   (rd_data)
  );

  assign b0_we = we_v[0];
  assign b1_we = we_v[1];
  assign b0_re = re_v[0];
  assign b1_re = re_v[1];

  assert_one_writer_R3 : assert property (@(posedge clk) disable iff (!rst_q_n)
    !(b0_we && b1_we)) else $error("both banks written");

  assert_read_bank_quiet_R4 : assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_sel ? !b1_we : !b0_we) else $error("read bank written");

  assert_read_path_R4 : assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_sel ? (b1_addr == rd_addr && b1_re == rd_en)
              : (b0_addr == rd_addr && b0_re == rd_en))
    else $error("read bank not on reader address");
endmodule

// File: tb/pp_frame_buf_tb_top.sv
module pp_frame_buf_tb_top;
  localparam int N  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n, rx_dv, rx_er, rd_frame_start, rd_en;
  logic [3:0]    rx_nib;
  logic [AW-1:0] rd_addr;
  logic [23:0]   rd_data, b0_wdata, b1_wdata, b0_rdata, b1_rdata;
  logic [AW-1:0] b0_addr, b1_addr;
  logic          frame_sel, b0_we, b0_re, b1_we, b1_re;

  logic [23:0] mem0 [N];
  logic [23:0] mem1 [N];
  int          we_cnt0 = 0, we_cnt1 = 0;
  int          checks = 0, fails = 0;

  always #2 clk = ~clk;

  pp_frame_buf #(.FRAME_PIX(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rx_nib(rx_nib),
    .rd_frame_start(rd_frame_start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .frame_sel(frame_sel),
    .b0_addr(b0_addr), .b0_wdata(b0_wdata), .b0_we(b0_we), .b0_re(b0_re), .b0_rdata(b0_rdata),
    .b1_addr(b1_addr), .b1_wdata(b1_wdata), .b1_we(b1_we), .b1_re(b1_re), .b1_rdata(b1_rdata)
  );

  assign b0_rdata = mem0[b0_addr];
  assign b1_rdata = mem1[b1_addr];

  always @(posedge clk) begin
    if (b0_we) begin mem0[b0_addr] <= b0_wdata; we_cnt0 <= we_cnt0 + 1; end
    if (b1_we) begin mem1[b1_addr] <= b1_wdata; we_cnt1 <= we_cnt1 + 1; end
  end

  function automatic logic [23:0] pat(input int f, input int p);
    return 24'((f * 24'h35B1F7 + p * 24'h0A9C63 + 24'h123457) ^ (p << (f % 5)));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_nib(input logic [3:0] n, input bit gap);
    @(negedge clk); rx_dv = 1'b1; rx_nib = n;
    if (gap) begin @(negedge clk); rx_dv = 1'b0; end
  endtask

  // nibble k: byte k/2 of (R,G,B), low half first
  task automatic put_pix(input logic [23:0] px, input bit gap);
    for (int k = 0; k < 6; k++) put_nib(px[(2 - k/2)*8 + (k%2)*4 +: 4], gap);
  endtask

  task automatic idle(input int n);
    @(negedge clk); rx_dv = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic boundary();
    @(negedge clk); rd_frame_start = 1'b1;
    @(negedge clk); rd_frame_start = 1'b0;
  endtask

  task automatic read_sweep(input int f, input bit bank, input string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); rd_addr = AW'(i); rd_en = 1'b1;
      #1;
      chk(rd_data == pat(f, i), req, rd_data, pat(f, i));
      chk((bank ? (b1_re && b1_addr == AW'(i) && !b1_we) : (b0_re && b0_addr == AW'(i) && !b0_we)),
          "R4", {23'b0, bank ? b1_re : b0_re}, 24'd1);
    end
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_dv = 1'b0; rx_er = 1'b0; rx_nib = '0;
    rd_frame_start = 1'b0; rd_en = 1'b0; rd_addr = '0;
    for (int i = 0; i < N; i++) begin mem0[i] = pat(1, i); mem1[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(frame_sel == 1'b0, "R1", {23'b0, frame_sel}, 24'd0);
    chk(!b0_we && !b1_we, "R1", {22'b0, b1_we, b0_we}, 24'd0);
    // R9 boundary with nothing pending
    boundary();
    chk(frame_sel == 1'b0, "R9", {23'b0, frame_sel}, 24'd0);
    // R4 reader on bank 0
    read_sweep(1, 1'b0, "R4");

    // frame 2 with idle gaps on odd pixels (R10), into bank 1
    for (int p = 0; p < N; p++) put_pix(pat(2, p), p[0]);
    idle(4);
    for (int i = 0; i < N; i++) chk(mem1[i] == pat(2, i), "R2_R3_R10", mem1[i], pat(2, i));
    chk(we_cnt1 == N && we_cnt0 == 0, "R3", 24'(we_cnt1), 24'(N));
    chk(frame_sel == 1'b0, "R5", {23'b0, frame_sel}, 24'd0);

    // pending: nibbles ignored (R6)
    put_pix(pat(9, 0), 1'b0);
    put_pix(pat(9, 1), 1'b0);
    idle(3);
    chk(we_cnt1 == N && we_cnt0 == 0, "R6", 24'(we_cnt0 + we_cnt1), 24'(N));
    chk(mem1[0] == pat(2, 0) && mem1[1] == pat(2, 1), "R6", mem1[0], pat(2, 0));

    // swap (R5)
    boundary();
    chk(frame_sel == 1'b1, "R5", {23'b0, frame_sel}, 24'd1);
    read_sweep(2, 1'b1, "R4");

    // partial frame then error (R8), boundary must not swap
    for (int p = 0; p < 3; p++) put_pix(pat(7, p), 1'b0);
    put_nib(4'hA, 1'b0);
    put_nib(4'h5, 1'b0);
    @(negedge clk); rx_dv = 1'b0; rx_er = 1'b1;
    @(negedge clk); rx_er = 1'b0;
    boundary();
    chk(frame_sel == 1'b1, "R8", {23'b0, frame_sel}, 24'd1);

    // clean frame 3 back to back: restart at address 0 of bank 0 (R7, R8)
    for (int p = 0; p < N; p++) put_pix(pat(3, p), 1'b0);
    idle(4);
    for (int i = 0; i < N; i++) chk(mem0[i] == pat(3, i), "R7_R8", mem0[i], pat(3, i));
    chk(we_cnt0 == N + 3 && we_cnt1 == N, "R8", 24'(we_cnt0), 24'(N + 3));
    boundary();
    chk(frame_sel == 1'b0, "R5", {23'b0, frame_sel}, 24'd0);
    read_sweep(3, 1'b0, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule